// File: doc/BRIEF.md
# Serial EEPROM Burst Read Master

This block fetches a run of consecutive 16-bit words from a small serial EEPROM. The EEPROM is reached over a chip select, a serial clock, a serial data line to the device and a serial data line back from it. The host presents a start address and a word count with a one-cycle start strobe. For every word the block then issues one complete read command. The command is a start bit, a two-bit read opcode and the address, most significant bit first. The block then clocks in the reply, drops the dummy bit the device sends first, and hands the word to the host as a one-cycle valid pulse.

The serial clock is made from the system clock. Two parameters set the number of system cycles in its high phase and in its low phase, so the device's minimum pulse widths can be met at any system frequency. The address width is a parameter: 6 bits for the small devices, 8 for the larger ones. Between words the chip select is dropped and one idle serial clock is applied. When the last word has been delivered and its closing clock is done, a single done pulse follows.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is high, and in the cycle after it is released, chip select, serial clock, serial data out, word valid and done are all low.
- R2: Each command shifts out, on successive serial clocks, a 1, then the opcode bits 1 and 0, then the ADDR_W address bits MSB first. Serial data out changes only while the serial clock is low.
- R3: Chip select rises while the serial clock is low and then spans one full serial clock (low phase, then high phase) before the first command bit. It stays high through all command clocks and all 17 reply clocks.
- R4: Every high phase of the serial clock lasts at least HI_CYC system cycles, and every low phase at least LO_CYC system cycles.
- R5: The data line from the device is sampled in the last system cycle of each high phase of the 17 reply clocks. The first sample is discarded, and the remaining 16 form the word, first sample in bit 15.
- R6: Each received word appears on the word output with word valid high for exactly one cycle.
- R7: After each word, chip select falls while the serial clock is low, and at least one full serial clock follows with chip select low before chip select rises again.
- R8: A burst of N words reads addresses start, start+1, …, start+N-1, wrapping modulo 2^ADDR_W, with exactly one command per word and in ascending order.
- R9: Done is high for exactly one cycle, after the last word of a burst has been presented.
- R10: A start strobe seen while a burst is in progress is ignored: the burst keeps its address and count, and no additional command follows it.
- R11: A start strobe with a count of zero raises done in the next cycle and causes no chip select or serial clock activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle burst request |
| start_addr_i | input | ADDR_W | First word address of the burst |
| count_i | input | CNT_W | Number of words to read |
| cs_o | output | 1 | EEPROM chip select, active high |
| sk_o | output | 1 | EEPROM serial clock |
| sdo_o | output | 1 | Serial data to the EEPROM |
| sdi_i | input | 1 | Serial data from the EEPROM |
| word_valid_o | output | 1 | One-cycle strobe marking word_o |
| word_o | output | DATA_W | Received word |
| done_o | output | 1 | One-cycle end-of-burst strobe |

## Verification
A wrong bit counter or state shows up on the serial pins within one serial clock. A command of the wrong length shifts the reply, and the word seen at the host then no longer matches the modelled memory. A slip in the address register shows as the device model decoding a wrong address in the very next command. A faulty phase timer or phase flag breaks a high or low phase minimum on the next edge of the serial clock, and a chip select fault breaks the setup or tail rule at the next word boundary. Mistakes in the word counter show only at the end of the burst, as a missing or extra command and a done pulse in the wrong place.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_READ,
    ST_TAIL
  } mwr_state_e;

  localparam logic       START_BIT = 1'b1;
  localparam logic [1:0] READ_OP   = 2'b10;

endpackage

// File: rtl/mwr_phase_timer.sv
module mwr_phase_timer #(
  parameter int HI_CYC = 40,
  parameter int LO_CYC = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic load_hi,
  output logic tick
);
  localparam int MAX_CYC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= CW'(LO_CYC - 1);
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_q <= load_hi ? CW'(HI_CYC - 1) : CW'(LO_CYC - 1);
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign tick = run && !restart && (cnt_q == '0);
endmodule

// File: rtl/mwr_cmd_shifter.sv
module mwr_cmd_shifter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_now,
  output logic         bit_next
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= load_val;
    end else if (shift) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign bit_now  = sh_q[W-1];
  assign bit_next = sh_q[W-2];
endmodule

// File: rtl/mwr_rx_shifter.sv
module mwr_rx_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic              din,
  output logic [DATA_W-1:0] word_next
);
  logic [DATA_W-2:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift) begin
      q <= {q[DATA_W-3:0], din};
    end
  end

  assign word_next = {q, din};
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mwr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int HI_CYC = 40,
  parameter int LO_CYC = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic              word_valid_o,
  output logic [DATA_W-1:0] word_o,
  output logic              done_o
);
  localparam int CMD_LEN = 3 + ADDR_W;
  localparam int RD_LEN  = DATA_W + 1;
  localparam int BIT_W   = $clog2(CMD_LEN + RD_LEN);

  mwr_state_e        state_q;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bitc_q;

  logic tick, launch, end_hi, last_word, last_cmd, last_rd;
  logic cmd_load, cmd_shift, bit_now, bit_next, rx_shift;
  logic [ADDR_W-1:0]  next_addr;
  logic [CMD_LEN-1:0] cmd_val;
  logic [DATA_W-1:0]  word_next;

  assign launch    = (state_q == ST_IDLE) && start_i && (count_i != '0);
  assign end_hi    = tick && sk_o;
  assign last_word = (left_q == CNT_W'(1));
  assign last_cmd  = (bitc_q == BIT_W'(CMD_LEN - 1));
  assign last_rd   = (bitc_q == BIT_W'(RD_LEN - 1));
  assign next_addr = launch ? start_addr_i : (addr_q + ADDR_W'(1));
  assign cmd_val   = {START_BIT, READ_OP, next_addr};
  assign cmd_load  = launch || ((state_q == ST_TAIL) && end_hi && !last_word);
  assign cmd_shift = (state_q == ST_CMD) && end_hi && !last_cmd;
  assign rx_shift  = (state_q == ST_READ) && end_hi;

  mwr_phase_timer #(
    .HI_CYC (HI_CYC),
    .LO_CYC (LO_CYC)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q != ST_IDLE),
    .restart (launch),
    .load_hi (!sk_o && !launch),
    .tick    (tick)
  );

  mwr_cmd_shifter #(
    .W (CMD_LEN)
  ) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd_load),
    .load_val (cmd_val),
    .shift    (cmd_shift),
    .bit_now  (bit_now),
    .bit_next (bit_next)
  );

  mwr_rx_shifter #(
    .DATA_W (DATA_W)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .shift     (rx_shift),
    .din       (sdi_i),
    .word_next (word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      left_q       <= '0;
      addr_q       <= '0;
      bitc_q       <= '0;
      cs_o         <= 1'b0;
      sk_o         <= 1'b0;
      sdo_o        <= 1'b0;
      word_valid_o <= 1'b0;
      word_o       <= '0;
      done_o       <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      done_o       <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          if (count_i == '0) begin
            done_o <= 1'b1;
          end else begin
            state_q <= ST_SETUP;
            cs_o    <= 1'b1;
            addr_q  <= start_addr_i;
            left_q  <= count_i;
          end
        end
      end else if (tick) begin
        if (!sk_o) begin
          sk_o <= 1'b1;
        end else begin
          sk_o <= 1'b0;
          case (state_q)
            ST_SETUP: begin
              state_q <= ST_CMD;
              bitc_q  <= '0;
              sdo_o   <= bit_now;
            end
            ST_CMD: begin
              if (last_cmd) begin
                state_q <= ST_READ;
                bitc_q  <= '0;
                sdo_o   <= 1'b0;
              end else begin
                bitc_q  <= bitc_q + BIT_W'(1);
                sdo_o   <= bit_next;
              end
            end
            ST_READ: begin
              if (last_rd) begin
                state_q      <= ST_TAIL;
                cs_o         <= 1'b0;
                word_valid_o <= 1'b1;
                word_o       <= word_next;
              end else begin
                bitc_q <= bitc_q + BIT_W'(1);
              end
            end
            ST_TAIL: begin
              if (last_word) begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
              end else begin
                left_q  <= left_q - CNT_W'(1);
                addr_q  <= next_addr;
                state_q <= ST_SETUP;
                cs_o    <= 1'b1;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
  parameter int HI_CYC = 40,
  parameter int LO_CYC = 14
) (
  input logic clk,
  input logic rst,
  input logic cs_o,
  input logic sk_o,
  input logic sdo_o,
  input logic word_valid_o,
  input logic done_o
);
  logic        sk_q;
  logic [15:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_q  <= 1'b0;
      len_q <= 16'hFFFF;
    end else begin
      sk_q  <= sk_o;
      if (sk_o != sk_q) len_q <= 16'd1;
      else if (len_q != 16'hFFFF) len_q <= len_q + 16'd1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cs_o && !sk_o && !sdo_o && !word_valid_o && !done_o));

  a_r2_sdo_stable_high: assert property (@(posedge clk) disable iff (rst)
    ($past(sk_o) && sk_o) |-> $stable(sdo_o));

  a_r4_high_min: assert property (@(posedge clk) disable iff (rst)
    (sk_q && !sk_o) |-> (len_q >= 16'(HI_CYC)));

  a_r4_low_min: assert property (@(posedge clk) disable iff (rst)
    (!sk_q && sk_o) |-> (len_q >= 16'(LO_CYC)));

  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_cs_edge_low: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs_o) || $fell(cs_o)) |-> !sk_o);
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(
  .HI_CYC (HI_CYC),
  .LO_CYC (LO_CYC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_o         (cs_o),
  .sk_o         (sk_o),
  .sdo_o        (sdo_o),
  .word_valid_o (word_valid_o),
  .done_o       (done_o)
);

// File: tb/mw_eeprom_reader_bench.sv
module mw_eeprom_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int HI = 3;
  localparam int LO = 2;
  localparam int NVEC = 4;
  localparam logic [13:0] VEC [NVEC] = '{
    {6'd0,  8'd1},
    {6'd5,  8'd3},
    {6'd62, 8'd3},
    {6'd40, 8'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic cs_o, sk_o, sdo_o, word_valid_o, done_o;
  logic sdi_i = 1'b0;
  logic [DW-1:0] word_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_reader #(
    .ADDR_W (AW), .DATA_W (DW), .CNT_W (CW), .HI_CYC (HI), .LO_CYC (LO)
  ) u_mw_eeprom_reader (
    .clk (clk), .rst (rst), .start_i (start_i), .start_addr_i (start_addr_i),
    .count_i (count_i), .cs_o (cs_o), .sk_o (sk_o), .sdo_o (sdo_o),
    .sdi_i (sdi_i), .word_valid_o (word_valid_o), .word_o (word_o),
    .done_o (done_o)
  );

  function automatic logic [15:0] mem_word(input int a);
    return 16'((32'h9C31 ^ ((a & 63) * 32'h0A13)) & 32'hFFFF);
  endfunction

  // monitor and device model, sampled away from the active edge
  int wn = 0, seen_n = 0, done_cnt = 0, words_at_done = 0, cs_rises = 0;
  int err_op = 0, err_setup = 0, err_tim = 0, err_tail = 0, err_dbl = 0;
  logic [15:0] words [64];
  int seen [64];
  logic prev_sk = 0, prev_cs = 0, prev_valid = 0, prev_done = 0, had_fall = 0;
  int sk_len = 1000, tail_edges = 0, setup_edges = 0, read_edges = 0;
  int dev_phase = 0, dev_bits = 0;
  logic [7:0] dev_sh = '0;
  logic [15:0] dev_word = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sk_o == prev_sk) sk_len = sk_len + 1;
      else begin
        if (prev_sk && sk_len < HI) err_tim = err_tim + 1;
        if (!prev_sk && sk_len < LO) err_tim = err_tim + 1;
        sk_len = 1;
      end
      if (!cs_o) begin
        if (prev_cs) begin
          if (read_edges < 17) err_setup = err_setup + 1;
          tail_edges = 0;
          had_fall = 1;
        end
        dev_phase = 0;
        if (sk_o && !prev_sk) tail_edges = tail_edges + 1;
      end else begin
        if (!prev_cs) begin
          if (had_fall && tail_edges < 1) err_tail = err_tail + 1;
          setup_edges = 0; read_edges = 0; dev_phase = 0;
          cs_rises = cs_rises + 1;
        end
        if (sk_o && !prev_sk) begin
          case (dev_phase)
            0: if (sdo_o) begin
                 if (setup_edges == 0) err_setup = err_setup + 1;
                 dev_phase = 1; dev_bits = 0;
               end else setup_edges = setup_edges + 1;
            1: begin
                 dev_sh = {dev_sh[6:0], sdo_o};
                 dev_bits = dev_bits + 1;
                 if (dev_bits == 8) begin
                   if (dev_sh[7:6] != 2'b10) err_op = err_op + 1;
                   if (seen_n < 64) seen[seen_n] = int'(dev_sh[5:0]);
                   seen_n = seen_n + 1;
                   dev_word = mem_word(int'(dev_sh[5:0]));
                   dev_phase = 2; read_edges = 0;
                 end
               end
            default: begin
                 if (read_edges == 0) sdi_i = 1'b0;
                 else if (read_edges <= 16) sdi_i = dev_word[16-read_edges];
                 read_edges = read_edges + 1;
               end
          endcase
        end
      end
      if (word_valid_o) begin
        if (prev_valid) err_dbl = err_dbl + 1;
        if (wn < 64) words[wn] = word_o;
        wn = wn + 1;
      end
      if (done_o) begin
        if (prev_done) err_dbl = err_dbl + 1;
        done_cnt = done_cnt + 1;
        words_at_done = wn;
      end
    end
    prev_sk = sk_o; prev_cs = cs_o; prev_valid = word_valid_o; prev_done = done_o;
  end

  int checks = 0, errors = 0;
  logic wd = 1'b0;

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input int a, input int n);
    @(negedge clk);
    start_i = 1'b1; start_addr_i = AW'(a); count_i = CW'(n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int base, input int limit);
    for (int c = 0; c < limit && done_cnt == base; c++) @(negedge clk);
  endtask

  task automatic run_burst(input int a, input int n);
    int b_wn, b_seen, b_done, b_op, b_su, b_tim, b_tail, b_dbl;
    b_wn = wn; b_seen = seen_n; b_done = done_cnt; b_op = err_op;
    b_su = err_setup; b_tim = err_tim; b_tail = err_tail; b_dbl = err_dbl;
    pulse_start(a, n);
    wait_done(b_done, 200 * n + 100);
    repeat (5) @(negedge clk);
    chk(wn - b_wn == n, "R8", "word count", wn - b_wn, n);
    chk(seen_n - b_seen == n, "R8", "command count", seen_n - b_seen, n);
    for (int i = 0; i < n; i++) begin
      chk(words[b_wn+i] == mem_word(a + i), "R5", "word value",
          words[b_wn+i], mem_word(a + i));
      chk(seen[b_seen+i] == ((a + i) & 63), "R8", "address order",
          seen[b_seen+i], (a + i) & 63);
    end
    chk(done_cnt - b_done == 1, "R9", "done pulses", done_cnt - b_done, 1);
    chk(words_at_done - b_wn == n, "R9", "words before done", words_at_done - b_wn, n);
    chk(err_op == b_op, "R2", "opcode errors", err_op - b_op, 0);
    chk(err_setup == b_su, "R3", "select setup/hold errors", err_setup - b_su, 0);
    chk(err_tim == b_tim, "R4", "clock phase errors", err_tim - b_tim, 0);
    chk(err_tail == b_tail, "R7", "tail clock errors", err_tail - b_tail, 0);
    chk(err_dbl == b_dbl, "R6", "long strobes", err_dbl - b_dbl, 0);
  endtask

  task automatic run_all();
    int b_done, b_rises, b_wn, b_seen;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({cs_o, sk_o, sdo_o, word_valid_o, done_o} == 5'b0, "R1", "outputs in reset",
        {cs_o, sk_o, sdo_o, word_valid_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({cs_o, sk_o, sdo_o, word_valid_o, done_o} == 5'b0, "R1", "outputs after reset",
        {cs_o, sk_o, sdo_o, word_valid_o, done_o}, 0);

    for (int v = 0; v < NVEC; v++) run_burst(int'(VEC[v][13:8]), int'(VEC[v][7:0]));

    // R11: zero count
    b_rises = cs_rises; b_done = done_cnt;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = 6'd9; count_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R11", "done next cycle", done_o, 1);
    chk(cs_o == 1'b0 && sk_o == 1'b0, "R11", "bus idle", {cs_o, sk_o}, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R11", "done single cycle", done_o, 0);
    repeat (30) @(negedge clk);
    chk(cs_rises == b_rises, "R11", "no select activity", cs_rises - b_rises, 0);
    chk(done_cnt - b_done == 1, "R11", "one done", done_cnt - b_done, 1);

    // R10: start during a burst is ignored
    b_done = done_cnt; b_rises = cs_rises; b_wn = wn; b_seen = seen_n;
    pulse_start(10, 2);
    repeat (50) @(negedge clk);
    pulse_start(30, 5);
    wait_done(b_done, 1000);
    repeat (300) @(negedge clk);
    chk(wn - b_wn == 2, "R10", "words in burst", wn - b_wn, 2);
    chk(cs_rises - b_rises == 2, "R10", "commands issued", cs_rises - b_rises, 2);
    chk(words[b_wn] == mem_word(10), "R10", "first word", words[b_wn], mem_word(10));
    chk(words[b_wn+1] == mem_word(11), "R10", "second word", words[b_wn+1], mem_word(11));
    chk(seen[b_seen+1] == 11, "R10", "second address", seen[b_seen+1], 11);
    chk(done_cnt - b_done == 1, "R10", "done count", done_cnt - b_done, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    if (wd) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual 1 expected 0");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule